// File: doc/BRIEF.md
# Parallel Flash Boot Address Sequencer

This block fetches a configuration image from an asynchronous parallel NOR flash during boot. A three-bit mode input picks the walk direction. Under the up code it starts at address zero and counts upward. Under the down code it starts at the all-ones address and counts downward. Any other code keeps it idle with the flash deselected. While reading, it holds chip enable and output enable low. It presents one address per configuration-clock cycle and samples the flash data on the rising edge. The samples leave the block as 16-bit words, each marked by a one-cycle valid strobe.

A static width input selects a 16-bit or an 8-bit flash. With an 8-bit flash only the low byte lane is used. Two consecutive bytes form one output word, and the earlier byte goes in the high half. Once the done input is seen, the address freezes, strobes stop and both enables are released. If the walk reaches its last address without done, the block stops. It then sets a sticky error flag and pulses a one-cycle fallback request, so that the surrounding logic can try another image.

Top module: `pflash_boot_seq`

## Requirements
- R1: While reset is low and on the first cycle after it, flash_ce_n and flash_oe_n are 1, word_valid is 0, err_flag is 0, fallback_req is 0 and flash_addr is 0.
- R2: Mode value 3'b010 loads address 0 on the first clock after reset and adds 1 to the address after every read.
- R3: Mode value 3'b011 loads the all-ones address (26'h3FFFFFF by default) and subtracts 1 from the address after every read.
- R4: Any mode value other than 3'b010 or 3'b011 leaves the block idle. The enables stay high, no strobe appears and the address stays 0.
- R5: With bus_x16 = 1, each read edge produces a word equal to flash_data at the address presented before that edge. word_valid is high for the single cycle after that edge.
- R6: With bus_x16 = 0, bits [7:0] of two successive reads form one word, the first byte in bits [15:8]. Data bits [15:8] are ignored, and a strobe follows every second read only.
- R7: When done_in is high on a clock edge during reading, no data is taken at that edge. From then on the address holds, no strobe is issued, and flash_ce_n and flash_oe_n return to 1.
- R8: When a read happens at the terminal address (all ones going up, zero going down) without done_in, that word is still delivered. err_flag then becomes 1 and stays 1 until reset, even if done_in arrives later.
- R9: fallback_req is a single-cycle pulse, raised once, in the same cycle err_flag first becomes 1.
- R10: flash_ce_n and flash_oe_n are both 0 for every cycle in which the block is reading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock; flash data sampled on rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_mode | input | 3 | 3'b010 count up, 3'b011 count down, others idle |
| bus_x16 | input | 1 | 1 for a 16-bit flash, 0 for an 8-bit flash |
| done_in | input | 1 | Configuration complete indication |
| flash_data | input | DATA_W | Data returned by the flash |
| flash_addr | output | ADDR_W | Address presented to the flash |
| flash_ce_n | output | 1 | Flash chip enable, active low |
| flash_oe_n | output | 1 | Flash output enable, active low |
| word_out | output | DATA_W | Assembled configuration word |
| word_valid | output | 1 | One-cycle strobe marking word_out |
| err_flag | output | 1 | Sticky address-exhausted flag |
| fallback_req | output | 1 | One-cycle fallback request |

## Verification
A wrong count direction or start value shows in the first strobed word, one cycle after the first read edge, because each word equals a fixed function of the address that produced it. A byte-phase error in 8-bit mode swaps halves or shifts the pairing, and shows in the first word as well. A faulty stop or terminal decision shows a few cycles after done or the last address. It appears as extra or missing strobes, a moving address, enables left low, or a missing, repeated or non-sticky error and fallback signal.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_HALT  = 2'd2,
        ST_FAULT = 2'd3
    } pfb_state_e;

    localparam logic [2:0] MODE_UP   = 3'b010;
    localparam logic [2:0] MODE_DOWN = 3'b011;

endpackage

// File: rtl/pfb_addr_gen.sv
module pfb_addr_gen #(
    parameter int ADDR_W = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              load_down,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              at_end
);

    localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] ONE      = {{(ADDR_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              down;
    } ag_t;

    ag_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (load) begin
            nxt_d.down = load_down;
            nxt_d.addr = load_down ? TOP_ADDR : '0;
        end else if (step && !at_end) begin
            nxt_d.addr = cur_q.down ? (cur_q.addr - ONE) : (cur_q.addr + ONE);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign addr   = cur_q.addr;
    assign at_end = cur_q.down ? (cur_q.addr == '0) : (cur_q.addr == TOP_ADDR);

    assert_count_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !at_end && !cur_q.down) |=> (addr == $past(addr) + ONE));

    assert_count_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !at_end && cur_q.down) |=> (addr == $past(addr) - ONE));

    assert_end_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (at_end && !load) |=> $stable(addr));

endmodule

// File: rtl/pfb_packer.sv
module pfb_packer #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              capture,
    input  logic              wide,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] word,
    output logic              valid
);

    localparam int BYTE_W = DATA_W / 2;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic              odd;
        logic [DATA_W-1:0] word;
        logic              valid;
    } pk_t;

    pk_t cur_q, nxt_d;

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.valid = 1'b0;
        if (clear) begin
            nxt_d.odd = 1'b0;
        end else if (capture) begin
            if (wide) begin
                nxt_d.word  = din;
                nxt_d.valid = 1'b1;
            end else if (!cur_q.odd) begin
                nxt_d.hi  = din[BYTE_W-1:0];
                nxt_d.odd = 1'b1;
            end else begin
                nxt_d.word  = {cur_q.hi, din[BYTE_W-1:0]};
                nxt_d.valid = 1'b1;
                nxt_d.odd   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign word  = cur_q.word;
    assign valid = cur_q.valid;

    assert_pair_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !$past(wide)) |-> (word[BYTE_W-1:0] == $past(din[BYTE_W-1:0])));

    assert_byte_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !clear && !wide && !cur_q.odd) |=> !valid);

endmodule

// File: rtl/pflash_boot_seq.sv
module pflash_boot_seq
    import pfb_pkg::*;
#(
    parameter int ADDR_W = 26,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        boot_mode,
    input  logic              bus_x16,
    input  logic              done_in,
    input  logic [DATA_W-1:0] flash_data,
    output logic [ADDR_W-1:0] flash_addr,
    output logic              flash_ce_n,
    output logic              flash_oe_n,
    output logic [DATA_W-1:0] word_out,
    output logic              word_valid,
    output logic              err_flag,
    output logic              fallback_req
);

    typedef struct packed {
        pfb_state_e st;
        logic       en_n;
        logic       err;
        logic       fb;
    } ctl_t;

    ctl_t cur_q, nxt_d;

    logic load, load_down, step, capture, at_end;
    logic mode_ok;

    assign mode_ok = (boot_mode == MODE_UP) || (boot_mode == MODE_DOWN);

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.fb  = 1'b0;
        load      = 1'b0;
        load_down = (boot_mode == MODE_DOWN);
        step      = 1'b0;
        capture   = 1'b0;
        unique case (cur_q.st)
            ST_IDLE: begin
                if (mode_ok) begin
                    load     = 1'b1;
                    nxt_d.st = ST_READ;
                end
            end
            ST_READ: begin
                if (done_in) begin
                    nxt_d.st = ST_HALT;
                end else begin
                    capture = 1'b1;
                    step    = 1'b1;
                    if (at_end) begin
                        nxt_d.st  = ST_FAULT;
                        nxt_d.err = 1'b1;
                        nxt_d.fb  = 1'b1;
                    end
                end
            end
            ST_HALT:  nxt_d.st = ST_HALT;
            ST_FAULT: nxt_d.st = ST_FAULT;
            default:  nxt_d.st = ST_IDLE;
        endcase
        nxt_d.en_n = (nxt_d.st != ST_READ);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.st   <= ST_IDLE;
            cur_q.en_n <= 1'b1;
            cur_q.err  <= 1'b0;
            cur_q.fb   <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    pfb_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_down (load_down),
        .step      (step),
        .addr      (flash_addr),
        .at_end    (at_end)
    );

    pfb_packer #(.DATA_W(DATA_W)) u_pack (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (load),
        .capture (capture),
        .wide    (bus_x16),
        .din     (flash_data),
        .word    (word_out),
        .valid   (word_valid)
    );

    assign flash_ce_n   = cur_q.en_n;
    assign flash_oe_n   = cur_q.en_n;
    assign err_flag     = cur_q.err;
    assign fallback_req = cur_q.fb;

    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_IDLE && !mode_ok) |=> (flash_ce_n && !word_valid));

    assert_x16_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && $past(bus_x16)) |-> (word_out == $past(flash_data)));

    assert_halt_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_HALT) |=> ($stable(flash_addr) && !word_valid && flash_ce_n));

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    assert_fb_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fallback_req |=> (!fallback_req && err_flag));

    assert_fb_with_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> fallback_req);

    assert_strobe_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> $past(!flash_ce_n && !flash_oe_n));

endmodule

// File: tb/sim_pflash_boot_seq.sv
module sim_pflash_boot_seq;

    localparam int AW  = 6;
    localparam int DW  = 16;
    localparam int TOP = (1 << AW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    boot_mode = 3'b000;
    logic          bus_x16 = 1'b1;
    logic          done_in = 1'b0;
    logic [DW-1:0] flash_data;
    logic [AW-1:0] flash_addr;
    logic          flash_ce_n, flash_oe_n, word_valid, err_flag, fallback_req;
    logic [DW-1:0] word_out;

    int checks = 0;
    int fails = 0;
    int mon_idx = 0;
    int fb_cnt = 0;
    int cycles = 0;
    logic cur_down = 1'b0;
    logic cur_wide = 1'b1;

    always #4 clk = ~clk;

    function automatic logic [DW-1:0] fdat(int a);
        return DW'(a * 1103 + 23100);
    endfunction

    assign flash_data = fdat(int'(flash_addr));

    pflash_boot_seq #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .boot_mode(boot_mode), .bus_x16(bus_x16),
        .done_in(done_in), .flash_data(flash_data), .flash_addr(flash_addr),
        .flash_ce_n(flash_ce_n), .flash_oe_n(flash_oe_n), .word_out(word_out),
        .word_valid(word_valid), .err_flag(err_flag), .fallback_req(fallback_req)
    );

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic logic [DW-1:0] exp_word(int k);
        int a0, a1;
        if (cur_wide) begin
            a0 = cur_down ? TOP - k : k;
            return fdat(a0);
        end
        a0 = cur_down ? TOP - 2 * k : 2 * k;
        a1 = cur_down ? a0 - 1 : a0 + 1;
        return {fdat(a0)[7:0], fdat(a1)[7:0]};
    endfunction

    // Word monitor: R5 (x16 words) and R6 (x8 byte pairs)
    always @(negedge clk) begin
        if (rst_n) begin
            if (word_valid) begin
                chk(cur_wide ? "R5" : "R6", int'(word_out), int'(exp_word(mon_idx)));
                mon_idx++;
            end
            if (fallback_req) fb_cnt++;
        end
    end

    task automatic finish_up();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got %0d cycles expected under 20000", cycles);
            finish_up();
        end
    end

    task automatic start(input logic [2:0] m, input logic w);
        rst_n = 1'b0;
        done_in = 1'b0;
        boot_mode = m;
        bus_x16 = w;
        cur_wide = w;
        cur_down = (m == 3'b011);
        repeat (2) @(negedge clk);
        mon_idx = 0;
        fb_cnt = 0;
        // R1: reset state
        chk("R1", int'({flash_ce_n, flash_oe_n, word_valid, err_flag, fallback_req}), 'b11000);
        chk("R1", int'(flash_addr), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // {mode, wide, reads, exp_words, exp_addr}
    localparam int NV = 7;
    localparam logic [27:0] VEC [NV] = '{
        {3'b010, 1'b1, 8'd10, 8'd10, 8'd10},
        {3'b011, 1'b1, 8'd7,  8'd7,  8'd56},
        {3'b010, 1'b0, 8'd8,  8'd4,  8'd8},
        {3'b011, 1'b0, 8'd12, 8'd6,  8'd51},
        {3'b000, 1'b1, 8'd5,  8'd0,  8'd0},
        {3'b111, 1'b0, 8'd5,  8'd0,  8'd0},
        {3'b010, 1'b0, 8'd5,  8'd2,  8'd5}
    };

    initial begin
        for (int v = 0; v < NV; v++) begin
            logic [2:0] m;
            logic       w;
            int         rd, ew, ea, hold_addr, hold_idx;
            m  = VEC[v][27:25];
            w  = VEC[v][24];
            rd = int'(VEC[v][23:16]);
            ew = int'(VEC[v][15:8]);
            ea = int'(VEC[v][7:0]);
            start(m, w);
            if (m == 3'b010 || m == 3'b011) begin
                chk("R10", int'({flash_ce_n, flash_oe_n}), 0);
                chk(m == 3'b010 ? "R2" : "R3", int'(flash_addr), m == 3'b010 ? 0 : TOP);
            end else begin
                chk("R4", int'({flash_ce_n, flash_oe_n}), 'b11);
            end
            repeat (rd) @(negedge clk);
            done_in = 1'b1;
            repeat (2) @(negedge clk);
            chk(m == 3'b011 ? "R3" : (m == 3'b010 ? "R2" : "R4"), int'(flash_addr), ea);
            chk(ew == 0 ? "R4" : "R7", mon_idx, ew);
            chk("R7", int'({flash_ce_n, flash_oe_n}), 'b11);
            hold_addr = int'(flash_addr);
            hold_idx  = mon_idx;
            repeat (4) @(negedge clk);
            chk("R7", int'(flash_addr), hold_addr);
            chk("R7", mon_idx, hold_idx);
            chk("R8", int'({err_flag, 4'(fb_cnt)}), 0);
        end

        // Terminal run upward, 16-bit
        start(3'b010, 1'b1);
        repeat (30) @(negedge clk);
        chk("R8", int'(err_flag), 0);
        chk("R10", int'({flash_ce_n, flash_oe_n}), 0);
        repeat (40) @(negedge clk);
        chk("R8", mon_idx, TOP + 1);
        chk("R8", int'(flash_addr), TOP);
        chk("R8", int'(err_flag), 1);
        chk("R9", fb_cnt, 1);
        chk("R7", int'({flash_ce_n, flash_oe_n}), 'b11);
        done_in = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8", int'(err_flag), 1);
        chk("R9", fb_cnt, 1);

        // Terminal run downward, 8-bit
        start(3'b011, 1'b0);
        repeat (70) @(negedge clk);
        chk("R8", mon_idx, (TOP + 1) / 2);
        chk("R8", int'(flash_addr), 0);
        chk("R8", int'(err_flag), 1);
        chk("R9", fb_cnt, 1);

        // Reset clears the sticky flag
        start(3'b000, 1'b1);
        chk("R1", int'(err_flag), 0);

        finish_up();
    end

endmodule